// File: doc/BRIEF.md
# NAND Sector Single-Bit Error Correcting Code Unit

This unit computes a 24-bit position-parity check code over a NAND sector while the sector's bytes stream through it. Each data bit has a 12-bit position, which is its byte index followed by its 3-bit bit index. The code holds two 12-bit parity halves. The upper half tracks the parity of the bits whose position has a given bit set. The lower half tracks the parity of the bits whose position has that bit clear. The code is driven inverted, so a fully erased sector (every byte 0xFF) yields a code of all ones. That matches the all-ones content of an erased spare area.

For a correction pass, the sector is streamed again. The stored code is then presented and a compare strobe is pulsed. The unit XORs the freshly captured code with the stored one and classifies the result as clean, single data-bit error (with its byte and bit position), error in the stored code alone, or uncorrectable. The data buffer itself is patched outside the unit, using the reported position.

Top module: `nand_ecc1`

## Requirements
- R1: After reset, code_valid and status_valid are 0, and status, fix_byte and fix_bit are 0.
- R2: One cycle after a byte accepted with in_eos, code_valid is 1 for that one cycle. At the same time code_out equals ~{H,L}. H[i] is the XOR of all data bits whose position {byte index, bit index} has bit i set. L[i] is the XOR of all data bits whose position has bit i clear. H sits in code_out[23:12] and L in code_out[11:0], and code_out[7:0] is the byte stored first.
- R3: A sector whose bytes are all 0xFF gives code_out = 24'hFFFFFF.
- R4: A byte accepted with in_sos discards all earlier context and takes byte index 0. Cycles with in_valid low change nothing, whatever in_sos, in_eos and in_byte hold.
- R5: Capturing the code at in_eos also clears the context. The next sector starts at byte index 0 with zero parity, even without in_sos.
- R6: Status is registered one cycle after cmp_go, with status_valid high in that cycle only. The syndrome is code_out XOR stored_code. The status encoding is 0 clean, 1 data bit corrected, 2 check code hit, 3 uncorrectable. A zero syndrome gives status 0. fix_byte and fix_bit are 0 for every status other than 1.
- R7: If syndrome[23:12] XOR syndrome[11:0] equals 12'hFFF and syndrome[23:15] < SECTOR_BYTES, the status is 1, fix_byte = syndrome[23:15] and fix_bit = syndrome[14:12].
- R8: If the halves XOR to 12'hFFF but syndrome[23:15] >= SECTOR_BYTES, the status is 3.
- R9: A syndrome with exactly one bit set gives status 2.
- R10: Any other nonzero syndrome gives status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | in_byte carries a sector byte this cycle |
| in_sos | input | 1 | Byte is the first of a sector (restart) |
| in_eos | input | 1 | Byte is the last of a sector (capture code) |
| in_byte | input | 8 | Sector data byte |
| stored_code | input | 24 | Check code read back from the spare area |
| cmp_go | input | 1 | Compare strobe |
| code_out | output | 24 | Inverted packed check code of the last sector |
| code_valid | output | 1 | code_out has just been updated |
| status | output | 2 | Compare outcome (encoding in R6) |
| status_valid | output | 1 | status and fix fields updated this cycle |
| fix_byte | output | 9 | Byte index to flip |
| fix_bit | output | 3 | Bit index to flip within fix_byte |

## Verification
A stale or misindexed accumulator corrupts only the code captured at the next in_eos. That code appears exactly one cycle after the closing byte, so a byte-index slip, a missed restart or an ignored idle cycle shows as a wrong code_out at a known cycle. A fault in the syndrome decoder shows in status and the fix fields one cycle after cmp_go. The bench sweeps every 12-bit position pattern, every single-bit syndrome and a set of multi-bit syndromes. Positions above a reduced sector size are included, so the range check is reached.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;
  localparam int HALF_W   = 12;
  localparam int CODE_W   = 2 * HALF_W;
  localparam int BYTE_IDX_W = 9;
  localparam int BIT_IDX_W  = 3;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_CODE_HIT = 2'd2,
    ST_UNCORR   = 2'd3
  } ecc_status_e;

  typedef struct packed {
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
  } parity_t;

  // Parity contribution of one byte: every set bit toggles its own position
  // into the upper half and the complement of it into the lower half.
  function automatic parity_t byte_contrib(input logic [7:0] d,
                                           input logic [BYTE_IDX_W-1:0] idx);
    parity_t r;
    logic [HALF_W-1:0] pos;
    r = '0;
    for (int k = 0; k < 8; k++) begin
      pos = {idx, BIT_IDX_W'(k)};
      if (d[k]) begin
        r.hi = r.hi ^ pos;
        r.lo = r.lo ^ ~pos;
      end
    end
    return r;
  endfunction

  // Packed code is inverted so an erased sector matches an erased spare area.
  function automatic logic [CODE_W-1:0] pack_code(input parity_t p);
    return ~{p.hi, p.lo};
  endfunction

  function automatic logic halves_complement(input logic [CODE_W-1:0] s);
    return (s[CODE_W-1:HALF_W] ^ s[HALF_W-1:0]) == {HALF_W{1'b1}};
  endfunction
endpackage

// File: rtl/nand_ecc1_accum.sv
module nand_ecc1_accum
  import nand_ecc1_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sos,
  input  logic                  in_eos,
  input  logic [7:0]            in_byte,
  output logic [CODE_W-1:0]     code_q,
  output logic                  code_valid_q,
  output logic [BYTE_IDX_W-1:0] byte_idx
);
  parity_t               acc_q, acc_nxt, acc_base;
  logic [BYTE_IDX_W-1:0] idx_q, idx_eff;

  always_comb begin
    idx_eff  = in_sos ? '0 : idx_q;
    acc_base = in_sos ? '0 : acc_q;
    acc_nxt  = acc_base ^ byte_contrib(in_byte, idx_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      idx_q        <= '0;
      code_q       <= '0;
      code_valid_q <= 1'b0;
    end else begin
      code_valid_q <= in_valid && in_eos;
      if (in_valid) begin
        if (in_eos) begin
          code_q <= pack_code(acc_nxt);
          acc_q  <= '0;
          idx_q  <= '0;
        end else begin
          acc_q <= acc_nxt;
          idx_q <= idx_eff + BYTE_IDX_W'(1);
        end
      end
    end
  end

  assign byte_idx = idx_q;
endmodule

// File: rtl/nand_ecc1_decide.sv
module nand_ecc1_decide
  import nand_ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmp_go,
  input  logic [CODE_W-1:0]     syndrome,
  output logic [1:0]            status_q,
  output logic                  status_valid_q,
  output logic [BYTE_IDX_W-1:0] fix_byte_q,
  output logic [BIT_IDX_W-1:0]  fix_bit_q
);
  localparam logic [BYTE_IDX_W:0] LIMIT = (BYTE_IDX_W+1)'(SECTOR_BYTES);

  ecc_status_e           st_nxt;
  logic [BYTE_IDX_W-1:0] byte_f, byte_nxt;
  logic [BIT_IDX_W-1:0]  bit_f, bit_nxt;

  assign byte_f = syndrome[CODE_W-1 -: BYTE_IDX_W];
  assign bit_f  = syndrome[HALF_W +: BIT_IDX_W];

  always_comb begin
    st_nxt   = ST_UNCORR;
    byte_nxt = '0;
    bit_nxt  = '0;
    if (syndrome == '0) begin
      st_nxt = ST_CLEAN;
    end else if (halves_complement(syndrome)) begin
      if ({1'b0, byte_f} < LIMIT) begin
        st_nxt   = ST_DATA_FIX;
        byte_nxt = byte_f;
        bit_nxt  = bit_f;
      end
    end else if ($onehot(syndrome)) begin
      st_nxt = ST_CODE_HIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q       <= '0;
      status_valid_q <= 1'b0;
      fix_byte_q     <= '0;
      fix_bit_q      <= '0;
    end else begin
      status_valid_q <= cmp_go;
      if (cmp_go) begin
        status_q   <= st_nxt;
        fix_byte_q <= byte_nxt;
        fix_bit_q  <= bit_nxt;
      end
    end
  end
endmodule

// File: rtl/nand_ecc1.sv
module nand_ecc1
  import nand_ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sos,
  input  logic        in_eos,
  input  logic [7:0]  in_byte,
  input  logic [23:0] stored_code,
  input  logic        cmp_go,
  output logic [23:0] code_out,
  output logic        code_valid,
  output logic [1:0]  status,
  output logic        status_valid,
  output logic [8:0]  fix_byte,
  output logic [2:0]  fix_bit
);
  logic [CODE_W-1:0]     syndrome;
  logic [BYTE_IDX_W-1:0] byte_idx;

  nand_ecc1_accum u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sos       (in_sos),
    .in_eos       (in_eos),
    .in_byte      (in_byte),
    .code_q       (code_out),
    .code_valid_q (code_valid),
    .byte_idx     (byte_idx)
  );

  assign syndrome = code_out ^ stored_code;

  nand_ecc1_decide #(.SECTOR_BYTES(SECTOR_BYTES)) u_decide (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmp_go         (cmp_go),
    .syndrome       (syndrome),
    .status_q       (status),
    .status_valid_q (status_valid),
    .fix_byte_q     (fix_byte),
    .fix_bit_q      (fix_bit)
  );
endmodule

// File: rtl/nand_ecc1_chk.sv
module nand_ecc1_chk #(
  parameter int SECTOR_BYTES = 512
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_eos,
  input logic        cmp_go,
  input logic        code_valid,
  input logic        status_valid,
  input logic [1:0]  status,
  input logic [8:0]  fix_byte,
  input logic [2:0]  fix_bit,
  input logic [23:0] syndrome,
  input logic [8:0]  byte_idx
);
  localparam logic [9:0] LIMIT = 10'(SECTOR_BYTES);

  p_code_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eos) |=> code_valid);
  p_code_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_eos) |=> !code_valid);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(byte_idx));
  p_ctx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eos) |=> (byte_idx == 9'd0));
  p_status_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |=> status_valid);
  p_status_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_go |=> !status_valid);
  p_zero_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_go && syndrome == 24'd0) |=> (status == 2'd0));
  p_fix_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && status != 2'd1) |-> (fix_byte == 9'd0 && fix_bit == 3'd0));
  p_fix_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && status == 2'd1) |-> ({1'b0, fix_byte} < LIMIT));
  p_code_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_go && $countones(syndrome) == 1) |=> (status == 2'd2));
endmodule

bind nand_ecc1 nand_ecc1_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_eos       (in_eos),
  .cmp_go       (cmp_go),
  .code_valid   (code_valid),
  .status_valid (status_valid),
  .status       (status),
  .fix_byte     (fix_byte),
  .fix_bit      (fix_bit),
  .syndrome     (syndrome),
  .byte_idx     (byte_idx)
);

// File: tb/nand_ecc1_tb.sv
module nand_ecc1_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sos = 1'b0, in_eos = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [23:0] stored_code = '0;
  logic        cmp_go = 1'b0;
  logic [23:0] code_out;
  logic        code_valid;
  logic [1:0]  status;
  logic        status_valid;
  logic [8:0]  fix_byte;
  logic [2:0]  fix_bit;

  int checks = 0;
  int errors = 0;
  logic [7:0]  sec [SB];
  logic [23:0] ref_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc1 #(.SECTOR_BYTES(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
    .in_eos(in_eos), .in_byte(in_byte), .stored_code(stored_code),
    .cmp_go(cmp_go), .code_out(code_out), .code_valid(code_valid),
    .status(status), .status_valid(status_valid), .fix_byte(fix_byte),
    .fix_bit(fix_bit)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Bench model: per bit, per position bit, count into the matching half.
  function automatic logic [23:0] model_code();
    logic [11:0] h = '0;
    logic [11:0] l = '0;
    for (int b = 0; b < SB; b++)
      for (int k = 0; k < 8; k++)
        if (sec[b][k])
          for (int i = 0; i < 12; i++) begin
            logic [11:0] pos;
            pos = 12'(b * 8 + k);
            if (pos[i]) h[i] = ~h[i];
            else        l[i] = ~l[i];
          end
    return ~{h, l};
  endfunction

  task automatic fill(input int mode);
    logic [15:0] lfsr = 16'hACE1;
    for (int b = 0; b < SB; b++) begin
      case (mode)
        0: sec[b] = 8'hFF;
        1: sec[b] = 8'h00;
        2: sec[b] = 8'(b * 7 + 3) ^ {7'd0, b[8]};
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          sec[b] = lfsr[7:0];
        end
      endcase
    end
  endtask

  // Streams sec[]; optionally inserts idle cycles carrying noise on the strobes.
  task automatic send_sector(input bit with_sos, input bit gaps);
    for (int b = 0; b < SB; b++) begin
      in_valid = 1'b1;
      in_byte  = sec[b];
      in_sos   = with_sos && (b == 0);
      in_eos   = (b == SB - 1);
      @(posedge clk); #1;
      in_valid = 1'b0; in_sos = 1'b0; in_eos = 1'b0;
      if (gaps && (b % 5 == 1) && (b != SB - 1)) begin
        in_byte = 8'h5A ^ 8'(b);
        in_sos  = 1'b1;
        in_eos  = (b % 10 == 1);
        @(posedge clk); #1;
        in_sos = 1'b0; in_eos = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic check_code(input string req, input logic [23:0] exp);
    chk(code_valid == 1'b1, {req, " code_valid"}, 32'(code_valid), 32'd1);
    chk(code_out == exp, {req, " code_out"}, 32'(code_out), 32'(exp));
  endtask

  task automatic do_cmp(input logic [23:0] s);
    stored_code = s;
    cmp_go = 1'b1;
    @(posedge clk); #1;
    cmp_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_status(input string req, input logic [1:0] st,
                              input logic [8:0] fb, input logic [2:0] fbit);
    chk(status_valid && status == st && fix_byte == fb && fix_bit == fbit, req,
        {19'd0, status_valid, status, fix_byte, fix_bit},
        {19'd0, 1'b1, st, fb, fbit});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(code_valid == 0 && status_valid == 0, "R1 valids", {30'd0, code_valid, status_valid}, 32'd0);
    chk(status == 0 && fix_byte == 0 && fix_bit == 0, "R1 fields",
        {18'd0, status, fix_byte, fix_bit}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3 erased sector
    fill(0);
    send_sector(1'b1, 1'b0);
    check_code("R3", 24'hFFFFFF);
    chk(model_code() == 24'hFFFFFF, "R3 model", 32'(model_code()), 32'hFFFFFF);
    @(negedge clk);
    chk(code_valid == 1'b0, "R2 single pulse", 32'(code_valid), 32'd0);
    #1;

    // R2 several patterns
    for (int m = 1; m < 4; m++) begin
      fill(m);
      send_sector(1'b1, 1'b0);
      check_code($sformatf("R2 pattern%0d", m), model_code());
    end

    // R4: junk before start, idle cycles with noisy strobes inside
    fill(2);
    for (int j = 0; j < 10; j++) begin
      in_valid = 1'b1; in_byte = 8'(j * 37 + 1);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    send_sector(1'b1, 1'b1);
    check_code("R4 restart and idle", model_code());

    // R5: next sector without start strobe
    fill(3);
    send_sector(1'b0, 1'b0);
    ref_code = model_code();
    check_code("R5 cleared context", ref_code);

    // R6 clean compare
    do_cmp(ref_code);
    check_status("R6 clean", 2'd0, 9'd0, 3'd0);

    // R7/R8 sweep over every position pattern
    for (int p = 0; p < 4096; p++) begin
      logic [11:0] pp;
      pp = 12'(p);
      do_cmp(ref_code ^ {pp, ~pp});
      if (int'(pp[11:3]) < SB)
        check_status("R7 correctable", 2'd1, pp[11:3], pp[2:0]);
      else
        check_status("R8 out of range", 2'd3, 9'd0, 3'd0);
    end

    // R9 every single-bit syndrome
    for (int i = 0; i < 24; i++) begin
      do_cmp(ref_code ^ (24'd1 << i));
      check_status("R9 code hit", 2'd2, 9'd0, 3'd0);
    end

    // R10 two-bit syndromes and near-miss patterns
    for (int i = 0; i < 24; i += 3) begin
      do_cmp(ref_code ^ (24'd1 << i) ^ (24'd1 << ((i + 7) % 24)));
      check_status("R10 double", 2'd3, 9'd0, 3'd0);
    end
    do_cmp(ref_code ^ {12'h123, ~12'h123 ^ 12'h001});
    check_status("R10 near miss", 2'd3, 9'd0, 3'd0);
    do_cmp(~ref_code);
    check_status("R10 all bits", 2'd3, 9'd0, 3'd0);

    // R7 end to end: flip a real data bit and compare with original code
    for (int t = 0; t < 3; t++) begin
      int fb;
      int fk;
      fb = (t == 0) ? 0 : (t == 1) ? SB - 1 : 200;
      fk = (t == 0) ? 0 : (t == 1) ? 7 : 3;
      fill(3);
      sec[fb][fk] = ~sec[fb][fk];
      send_sector(1'b1, 1'b0);
      do_cmp(ref_code);
      check_status("R7 data flip", 2'd1, 9'(fb), 3'(fk));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule